// File: doc/BRIEF.md
# Command Ring Fetch Engine

The block drains a circular ring of 32-bit command words held in local memory. A host producer writes words into the ring storage and then moves a write pointer forward through a small register port. The engine reads words from its read pointer up to the write pointer over a synchronous memory read port and presents them in order on a valid/ready stream. It does not interpret the words.

Both pointers are word indices that wrap modulo the ring size, which must be a power of two. The host can read back the write pointer, the read pointer, a free-space figure in bytes and a status word. Two pointers that are equal mean the ring is empty. The free-space figure is therefore never zero: with equal pointers it reports the whole ring. A producer may start a burst of n words only when the free space is strictly greater than 4n bytes. It also holds off while the free space is below 128 bytes.

An optional overread mode is selected by `quirk_en`. In this mode the fetch address runs up to `OVR_WORDS` words past the last ring entry before it wraps. The producer keeps a mirror of the first `OVR_WORDS` entries in that extra region. `quirk_en` may change only while the engine is idle.

Top module: `cmd_ring_fetch`

## Requirements
- R1: A synchronous reset sets both pointers to 0, drops `busy` and `cmd_valid`, and leaves no read in flight. After reset the free space reads `RING_WORDS*4` and the status word reads 0.
- R2: A host write to register 0 loads the write pointer with `host_wdata` masked by `RING_WORDS-1`. A read of register 0 in the following cycle returns that masked value.
- R3: Host writes to registers 1, 2 and 3 change no pointer and no output.
- R4: Every word placed between the read and write pointers is delivered on the stream exactly once and in ring order, also across many wraps of the ring.
- R5: Register 3 returns the free space in bytes. It is computed as ((rptr - wptr) mod RING_WORDS) * 4, and it reports `RING_WORDS*4` when the two pointers are equal.
- R6: Register 2 returns the status word. Bits [11:0] hold the pending word count (wptr - rptr) mod RING_WORDS. Bit 16 is `busy`. Bit 31 is active, which means a read is in flight or a word waits at the output. All other bits are 0.
- R7: `busy` is a register. It is set one cycle after the pointers differ, a read is in flight, or a word waits at the output. It clears one cycle after all three conditions have ended.
- R8: With `quirk_en` low, every memory read address equals the current read pointer. Addresses therefore stay below `RING_WORDS`, and successive reads step by +1 modulo `RING_WORDS`.
- R9: With `quirk_en` high, the read that follows address `RING_WORDS-1` uses address `RING_WORDS`. Reads continue upward to `RING_WORDS+OVR_WORDS-1`, and the next read after that uses address `OVR_WORDS`.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` holds its value.
- R11: A memory read is issued only when the read pointer differs from the write pointer. The read pointer advances by exactly one for each read issued, and it does not move otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| quirk_en | input | 1 | Selects the overread-past-end fetch mode |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 write pointer, 1 read pointer, 2 status, 3 free bytes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| mem_rd_en | output | 1 | Ring memory read request |
| mem_addr | output | clog2(RING_WORDS+OVR_WORDS) | Ring memory word address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Downstream accepts the word |
| cmd_data | output | 32 | Command word |
| busy | output | 1 | Engine has work outstanding (registered) |

## Verification
The bench first fills the ring to one word short of full while output is stalled. It then checks the free-space figure in the state where the read pointer is ahead of the write pointer. A design that left out the wrap correction would report a negative or huge free space here. A design that treated equal pointers as full would report zero free space after a drain. Long producer runs cross the ring end several times in both fetch modes under random backpressure. Every read address is compared with the expected address sequence, so an overread mode that wrapped at the wrong point, or failed to resume at entry `OVR_WORDS`, would show up as an address mismatch or as wrong data. The timing of the `busy` fall is checked to the cycle after the last handshake, and stalled output words are watched so that any change in them is caught.

// File: rtl/crf_pkg.sv
`timescale 1ns/1ps
package crf_pkg;
    // Host register selects
    localparam logic [1:0] HREG_WPTR = 2'd0;
    localparam logic [1:0] HREG_RPTR = 2'd1;
    localparam logic [1:0] HREG_STAT = 2'd2;
    localparam logic [1:0] HREG_FREE = 2'd3;

    // Status word layout
    localparam int STAT_CNT_W      = 12;
    localparam int STAT_BUSY_BIT   = 16;
    localparam int STAT_ACTIVE_BIT = 31;

    localparam int WORD_W     = 32;
    localparam int BYTES_LOG2 = 2;
endpackage

// File: rtl/crf_wptr_reg.sv
`timescale 1ns/1ps
module crf_wptr_reg #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    output logic [PW-1:0] wptr
);
    typedef struct packed {
        logic [PW-1:0] wptr;
    } wp_state_t;

    wp_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.wptr = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wptr = s_q.wptr;
endmodule

// File: rtl/crf_fetch.sv
`timescale 1ns/1ps
module crf_fetch #(
    parameter int RING_WORDS = 1024,
    parameter int OVR_WORDS  = 32,
    localparam int PW  = $clog2(RING_WORDS),
    localparam int MAW = $clog2(RING_WORDS + OVR_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           quirk_en,
    input  logic [PW-1:0]  wptr,
    input  logic           credit_ok,
    output logic [PW-1:0]  rptr,
    output logic           mem_rd_en,
    output logic [MAW-1:0] mem_addr,
    output logic           rd_inflight
);
    localparam int END_PHYS = RING_WORDS + OVR_WORDS;

    typedef struct packed {
        logic [MAW-1:0] phys;
        logic           inflight;
    } fe_state_t;

    fe_state_t s_d, s_q;

    logic          issue;
    logic [MAW:0]  phys_inc;
    logic [PW-1:0] log_inc;

    always_comb begin
        s_d      = s_q;
        issue    = (s_q.phys[PW-1:0] != wptr) && credit_ok;
        phys_inc = {1'b0, s_q.phys} + (MAW+1)'(1);
        log_inc  = s_q.phys[PW-1:0] + PW'(1);
        s_d.inflight = issue;
        if (issue) begin
            if (quirk_en && (phys_inc < (MAW+1)'(END_PHYS))) begin
                s_d.phys = phys_inc[MAW-1:0];
            end else begin
                s_d.phys = {{(MAW-PW){1'b0}}, log_inc};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rptr        = s_q.phys[PW-1:0];
    assign mem_rd_en   = issue;
    assign mem_addr    = quirk_en ? s_q.phys : {{(MAW-PW){1'b0}}, s_q.phys[PW-1:0]};
    assign rd_inflight = s_q.inflight;
endmodule

// File: rtl/crf_outq.sv
`timescale 1ns/1ps
module crf_outq #(
    parameter int DW    = 32,
    parameter int DEPTH = 2,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] slots;
        logic [IW-1:0]            wr;
        logic [IW-1:0]            rd;
        logic [CW-1:0]            cnt;
    } oq_state_t;

    oq_state_t s_d, s_q;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.slots[s_q.wr] = push_data;
            s_d.wr            = bump(s_q.wr);
        end
        if (pop) begin
            s_d.rd = bump(s_q.rd);
        end
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = (s_q.cnt != '0);
    assign data  = s_q.slots[s_q.rd];
    assign count = s_q.cnt;
endmodule

// File: rtl/cmd_ring_fetch.sv
`timescale 1ns/1ps
module cmd_ring_fetch
    import crf_pkg::*;
#(
    parameter int RING_WORDS = 1024,
    parameter int OVR_WORDS  = 32,
    parameter int Q_DEPTH    = 2,
    localparam int PW  = $clog2(RING_WORDS),
    localparam int MAW = $clog2(RING_WORDS + OVR_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           quirk_en,
    input  logic           host_we,
    input  logic [1:0]     host_addr,
    input  logic [31:0]    host_wdata,
    output logic [31:0]    host_rdata,
    output logic           mem_rd_en,
    output logic [MAW-1:0] mem_addr,
    input  logic [31:0]    mem_rdata,
    output logic           cmd_valid,
    input  logic           cmd_ready,
    output logic [31:0]    cmd_data,
    output logic           busy
);
    localparam int CW = $clog2(Q_DEPTH + 1);
    localparam int BW = PW + BYTES_LOG2 + 1;

    typedef struct packed {
        logic busy;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          rd_inflight;
    logic          credit_ok;
    logic          pop;
    logic [CW-1:0] q_cnt;
    logic [CW:0]   load;
    logic [PW-1:0] gap;
    logic [PW-1:0] pending;
    logic [PW:0]   free_words;
    logic [BW-1:0] free_bytes;
    logic          active;
    logic [31:0]   status;

    crf_wptr_reg #(.PW(PW)) i_wptr (
        .clk      (clk),
        .rst      (rst),
        .load     (host_we && (host_addr == HREG_WPTR)),
        .load_val (host_wdata[PW-1:0]),
        .wptr     (wptr)
    );

    crf_fetch #(.RING_WORDS(RING_WORDS), .OVR_WORDS(OVR_WORDS)) i_fetch (
        .clk         (clk),
        .rst         (rst),
        .quirk_en    (quirk_en),
        .wptr        (wptr),
        .credit_ok   (credit_ok),
        .rptr        (rptr),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .rd_inflight (rd_inflight)
    );

    crf_outq #(.DW(WORD_W), .DEPTH(Q_DEPTH)) i_outq (
        .clk       (clk),
        .rst       (rst),
        .push      (rd_inflight),
        .push_data (mem_rdata),
        .pop       (pop),
        .valid     (cmd_valid),
        .data      (cmd_data),
        .count     (q_cnt)
    );

    always_comb begin
        pop        = cmd_valid && cmd_ready;
        load       = {1'b0, q_cnt} + (CW+1)'(rd_inflight) - (CW+1)'(pop);
        credit_ok  = (load < (CW+1)'(Q_DEPTH));

        gap        = rptr - wptr;
        pending    = wptr - rptr;
        free_words = (gap == '0) ? (PW+1)'(RING_WORDS) : {1'b0, gap};
        free_bytes = {free_words, {BYTES_LOG2{1'b0}}};

        active     = rd_inflight || cmd_valid;
        s_d        = s_q;
        s_d.busy   = (rptr != wptr) || active;

        status                   = '0;
        status[STAT_CNT_W-1:0]   = STAT_CNT_W'(pending);
        status[STAT_BUSY_BIT]    = s_q.busy;
        status[STAT_ACTIVE_BIT]  = active;

        case (host_addr)
            HREG_WPTR: host_rdata = 32'(wptr);
            HREG_RPTR: host_rdata = 32'(rptr);
            HREG_STAT: host_rdata = status;
            default:   host_rdata = 32'(free_bytes);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
endmodule

// File: rtl/crf_checker.sv
`timescale 1ns/1ps
module crf_checker #(
    parameter int RING_WORDS = 1024,
    parameter int OVR_WORDS  = 32,
    localparam int PW  = $clog2(RING_WORDS),
    localparam int MAW = $clog2(RING_WORDS + OVR_WORDS),
    localparam int BW  = PW + 3
) (
    input logic           clk,
    input logic           rst,
    input logic           quirk_en,
    input logic           host_we,
    input logic [1:0]     host_addr,
    input logic [31:0]    host_wdata,
    input logic           mem_rd_en,
    input logic [MAW-1:0] mem_addr,
    input logic           cmd_valid,
    input logic           cmd_ready,
    input logic [31:0]    cmd_data,
    input logic           busy,
    input logic [PW-1:0]  rptr,
    input logic [PW-1:0]  wptr,
    input logic [BW-1:0]  free_bytes
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (rptr == '0 && wptr == '0 && !busy && !cmd_valid)); // R1

    AST_WPTR_MASKED: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_addr == 2'd0) |=>
            (32'(wptr) == ($past(host_wdata) & 32'(RING_WORDS - 1)))); // R2

    AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rptr == wptr) |-> (free_bytes == BW'(RING_WORDS * 4))); // R5

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
        (rptr != wptr || cmd_valid) |=> busy); // R7

    AST_NORMAL_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!quirk_en && mem_rd_en) |-> (mem_addr == MAW'(rptr))); // R8

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R10

    AST_READ_GUARD: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (rptr != wptr)); // R11

    AST_RPTR_STILL: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_en |=> $stable(rptr)); // R11
endmodule

bind cmd_ring_fetch crf_checker #(
    .RING_WORDS (RING_WORDS),
    .OVR_WORDS  (OVR_WORDS)
) i_crf_checker (
    .clk        (clk),
    .rst        (rst),
    .quirk_en   (quirk_en),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_data   (cmd_data),
    .busy       (busy),
    .rptr       (rptr),
    .wptr       (wptr),
    .free_bytes (free_bytes)
);

// File: tb/test_cmd_ring_fetch.sv
`timescale 1ns/1ps
module test_cmd_ring_fetch;
    localparam int N    = 1024;
    localparam int OVR  = 32;
    localparam int MASK = N - 1;
    localparam int MAW  = $clog2(N + OVR);

    logic           clk = 1'b0;
    logic           rst;
    logic           quirk_en;
    logic           host_we;
    logic [1:0]     host_addr;
    logic [31:0]    host_wdata;
    logic [31:0]    host_rdata;
    logic           mem_rd_en;
    logic [MAW-1:0] mem_addr;
    logic [31:0]    mem_rdata;
    logic           cmd_valid;
    logic           cmd_ready;
    logic [31:0]    cmd_data;
    logic           busy;

    logic [31:0] mem_arr [0:N+OVR-1];
    logic [31:0] exp_q [$];
    int checks = 0;
    int fails = 0;
    int seq = 0;
    int sw_wptr = 0;
    int ready_pct = 0;
    int exp_addr = 0;
    int mirror_reads = 0;

    always #10 clk = ~clk;

    cmd_ring_fetch i_cmd_ring_fetch (
        .clk        (clk),
        .rst        (rst),
        .quirk_en   (quirk_en),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_data   (cmd_data),
        .busy       (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Synchronous ring memory model
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_arr[mem_addr];
    end

    // Monitor: drives backpressure, scores words and read addresses
    always begin
        @(negedge clk);
        cmd_ready = ($urandom_range(0, 99) < ready_pct);
        #1;
        if (cmd_valid && cmd_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 word with empty scoreboard", cmd_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(cmd_data == e, "R4 order/data", cmd_data, e);
            end
        end
        if (mem_rd_en) begin
            int nxt;
            if (int'(mem_addr) >= N) mirror_reads++;
            chk(int'(mem_addr) == exp_addr, quirk_en ? "R9 overread address" : "R8 address",
                32'(mem_addr), 32'(exp_addr));
            nxt = int'(mem_addr) + 1;
            if (quirk_en) exp_addr = (nxt < N + OVR) ? nxt : OVR;
            else          exp_addr = nxt & MASK;
        end
    end

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        host_addr = a;
        #2;
        d = host_rdata;
    endtask

    task automatic push_burst(input int n);
        logic [31:0] f;
        logic [31:0] rb;
        forever begin
            host_read(2'd3, f);
            if (f >= 128 && int'(f) > 4 * n) break;
            @(negedge clk);
        end
        for (int k = 0; k < n; k++) begin
            int idx;
            logic [31:0] v;
            idx = (sw_wptr + k) & MASK;
            v = 32'hC0DE_0000 ^ 32'(seq * 7919);
            seq++;
            mem_arr[idx] = v;
            if (idx < OVR) mem_arr[N + idx] = v;
            exp_q.push_back(v);
        end
        sw_wptr = (sw_wptr + n) & MASK;
        host_write(2'd0, 32'(sw_wptr) | 32'hA5A5_0000);
        host_read(2'd0, rb);
        chk(rb == 32'(sw_wptr), "R2 masked write pointer readback", rb, 32'(sw_wptr));
    endtask

    task automatic drain_and_check(input string tag);
        logic [31:0] v;
        ready_pct = 70;
        while (exp_q.size() != 0) @(negedge clk);
        #2;
        chk(busy == 1'b1, {"R7 busy one cycle after last word ", tag}, 32'(busy), 32'h1);
        chk(cmd_valid == 1'b0, {"R4 no extra word ", tag}, 32'(cmd_valid), 32'h0);
        @(negedge clk);
        #2;
        chk(busy == 1'b0, {"R7 busy cleared ", tag}, 32'(busy), 32'h0);
        host_read(2'd3, v);
        chk(v == 32'(N * 4), {"R5 equal pointers give full ring ", tag}, v, 32'(N * 4));
        host_read(2'd2, v);
        chk(v == 32'h0, {"R6 idle status ", tag}, v, 32'h0);
    endtask

    task automatic stream(input int total);
        int sent = 0;
        while (sent < total) begin
            int n;
            n = 1 + $urandom_range(0, 39);
            if (n > total - sent) n = total - sent;
            push_burst(n);
            sent += n;
            repeat ($urandom_range(0, 5)) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0 pending words", exp_q.size());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, r, st, f, d0;
        int pend, g, expf;
        for (int i = 0; i < N + OVR; i++) mem_arr[i] = 32'h0;
        void'($urandom(32'h1234_5678));
        rst = 1'b1; quirk_en = 1'b0; host_we = 1'b0; host_addr = 2'd0; host_wdata = 32'h0;
        repeat (3) @(negedge clk);

        // R1 reset state
        #2;
        chk(busy == 1'b0 && cmd_valid == 1'b0, "R1 busy/valid low in reset", {busy, cmd_valid}, 32'h0);
        host_read(2'd1, v); chk(v == 32'h0, "R1 read pointer zero", v, 32'h0);
        host_read(2'd0, v); chk(v == 32'h0, "R1 write pointer zero", v, 32'h0);
        host_read(2'd3, v); chk(v == 32'(N * 4), "R1 free space full", v, 32'(N * 4));
        host_read(2'd2, v); chk(v == 32'h0, "R1 status zero", v, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R3 writes to read-only registers ignored
        host_write(2'd1, 32'h0000_0155);
        host_write(2'd2, 32'hFFFF_FFFF);
        host_write(2'd3, 32'hFFFF_FFFF);
        @(negedge clk); #2;
        host_read(2'd1, v); chk(v == 32'h0, "R3 read pointer untouched", v, 32'h0);
        host_read(2'd3, v); chk(v == 32'(N * 4), "R3 free space untouched", v, 32'(N * 4));
        chk(busy == 1'b0 && cmd_valid == 1'b0, "R3 engine stays idle", {busy, cmd_valid}, 32'h0);

        // R2 high bits masked away: pointer stays zero, nothing fetched
        host_write(2'd0, 32'hFFFF_FC00);
        host_read(2'd0, v); chk(v == 32'h0, "R2 masked to zero", v, 32'h0);
        @(negedge clk); #2;
        chk(busy == 1'b0, "R2/R11 no fetch on equal pointers", 32'(busy), 32'h0);

        // Near-full ring with output stalled
        ready_pct = 0;
        push_burst(N - 1);
        repeat (10) @(negedge clk);
        #2;
        host_read(2'd1, r);
        host_read(2'd2, st);
        host_read(2'd3, f);
        pend = (sw_wptr - int'(r)) & MASK;
        g    = (int'(r) - sw_wptr) & MASK;
        expf = ((g == 0) ? N : g) * 4;
        chk(st[11:0] == 12'(pend), "R6 pending count", 32'(st[11:0]), 32'(pend));
        chk(st[16] == 1'b1, "R6 busy bit", 32'(st[16]), 32'h1);
        chk(st[31] == 1'b1, "R6 active bit", 32'(st[31]), 32'h1);
        chk((st & 32'h7FFE_F000) == 32'h0, "R6 reserved bits zero", st, 32'h0);
        chk(f == 32'(expf), "R5 free space with read ahead of write", f, 32'(expf));
        chk(r != 32'h0 && int'(r) < N, "R11 read pointer advanced", r, 32'h1);
        d0 = cmd_data;
        chk(d0 == exp_q[0], "R4 head word presented", d0, exp_q[0]);
        repeat (5) @(negedge clk);
        #2;
        chk(cmd_valid && cmd_data == d0, "R10 word held under stall", cmd_data, d0);
        drain_and_check("after near-full");

        // Normal mode, several wraps
        stream(3 * N + 300);
        drain_and_check("normal");
        chk(mirror_reads == 0, "R8 no address past ring end", 32'(mirror_reads), 32'h0);

        // Overread mode, at least one more wrap
        @(negedge clk);
        quirk_en = 1'b1;
        stream(2 * N + 200);
        drain_and_check("overread");
        chk(mirror_reads >= OVR, "R9 mirror region used", 32'(mirror_reads), 32'(OVR));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule